// File: doc/BRIEF.md
# Dual-Mode Parallel Host Bus Decoder

This block is the parallel front end of a display controller's host port. A host processor reaches it through an active-low chip select, a data/command select line, two control strobes and an 8-bit bidirectional data bus. A static style pin picks how the two strobes are read. In enable-plus-direction (68-style) operation, one line is an active-high enable and the other gives the direction. In split-strobe (80-style) operation, the two lines are separate active-low read and write strobes. A second static input, the parallel select, enables the whole path.

Every completed access is sorted into one of four kinds: instruction write, status read, display data write or display data read. On reads the block drives the bus straight from the pins, without waiting for the clock. The byte comes from a status input or from a display-memory input, chosen by the data/command select. All pins are synchronised into the system clock domain. There, a small state machine watches for the trailing edge of the strobe and then emits a one-cycle pulse that carries the kind and the byte seen on the bus.

The state machine has five states. ST_IDLE goes to ST_WR_ACT on a write strobe or to ST_RD_ACT on a read strobe; a strobe clash sends it to ST_DRAIN. ST_WR_ACT and ST_RD_ACT go to ST_COMMIT when the strobe ends. They go to ST_DRAIN if the port is deselected or the strobes clash while the access is still open. ST_COMMIT returns to ST_IDLE after one cycle. ST_DRAIN returns to ST_IDLE once every strobe is inactive.

Top module: `host_bus_decoder`

## Requirements
- R1: With style_sel=1, ctl_a is an active-high enable and ctl_b the direction (1 = read, 0 = write); an access completes when ctl_a falls.
- R2: With style_sel=0, ctl_a is an active-low read strobe and ctl_b an active-low write strobe; an access completes when its strobe returns high.
- R3: acc_kind is {dc_sel, read}: 2'b00 instruction write, 2'b01 status read, 2'b10 display data write, 2'b11 display data read, with dc_sel taken at the start of the strobe.
- R4: Each completed access raises acc_valid with acc_kind and acc_byte, where acc_byte is the byte on the bus during the strobe: the host's byte for a write, the driven byte for a read.
- R5: bus_oe is 1 and bus_io carries mem_in when dc_sel=1 or status_in when dc_sel=0, exactly while par_sel=1, cs_n=0 and a read strobe is active. Otherwise bus_oe is 0 and bus_io is released.
- R6: While cs_n is high the bus is not driven and strobes produce no acc_valid.
- R7: While par_sel is low the bus is not driven and strobes produce no acc_valid.
- R8: In split-strobe style, both strobes low at once is no access: the bus is not driven, and no acc_valid follows until both strobes have returned high.
- R9: If cs_n rises or par_sel falls while a strobe is still active, the access is dropped and no acc_valid is produced for it.
- R10: acc_valid is high for exactly one cycle, rising on the (SYNC_STAGES+1)th rising clock edge after the trailing strobe edge.
- R11: After reset, acc_valid=0, acc_kind=2'b00, acc_byte=0 and bus_oe=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| par_sel | input | 1 | Parallel path enable, active high |
| style_sel | input | 1 | 1: enable+direction strobes, 0: split active-low strobes |
| cs_n | input | 1 | Chip select, active low |
| dc_sel | input | 1 | 1: display data, 0: instruction/status |
| ctl_a | input | 1 | Enable (style 1) or read strobe, active low (style 0) |
| ctl_b | input | 1 | Direction, 1 = read (style 1) or write strobe, active low (style 0) |
| bus_io | inout | 8 | Bidirectional host data bus |
| bus_oe | output | 1 | High while the block drives bus_io |
| status_in | input | 8 | Status byte returned on status reads |
| mem_in | input | 8 | Display-memory byte returned on data reads |
| acc_valid | output | 1 | One-cycle pulse per completed access |
| acc_kind | output | 2 | Access kind, valid with acc_valid |
| acc_byte | output | 8 | Byte carried by the access, valid with acc_valid |

## Verification
The four access kinds are swept in both strobe styles with several byte values. Status and memory inputs are always set to different values, so a wrong select on the read path shows up as a wrong byte. Separate runs cover a deselected chip, a disabled parallel path, clashing split strobes (released together and released one at a time) and a chip select that drops in the middle of a write. These runs tell a missing gate on the drive path apart from a missing gate on the commit path. Each accepted access is timed edge by edge, so an extra or missing register stage, or a pulse wider than one cycle, is caught.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

    localparam int unsigned BUS_W = 8;

    typedef enum logic [1:0] {
        K_CMD_WR  = 2'b00,
        K_STAT_RD = 2'b01,
        K_MEM_WR  = 2'b10,
        K_MEM_RD  = 2'b11
    } acc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WR_ACT = 3'd1,
        ST_RD_ACT = 3'd2,
        ST_COMMIT = 3'd3,
        ST_DRAIN  = 3'd4
    } fsm_state_e;

    typedef struct packed {
        logic             par_sel;
        logic             style_sel;
        logic             cs_n;
        logic             dc_sel;
        logic             ctl_a;
        logic             ctl_b;
        logic [BUS_W-1:0] data;
    } pin_bundle_t;

    localparam int unsigned PIN_W = $bits(pin_bundle_t);

endpackage

// File: rtl/hbd_sync.sv
module hbd_sync #(
    parameter int unsigned       WIDTH   = 1,
    parameter int unsigned       STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[0] <= RST_VAL;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[i] <= RST_VAL;
                    else        stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hbd_ctl_decode.sv
module hbd_ctl_decode (
    input  logic style_sel,
    input  logic ctl_a,
    input  logic ctl_b,
    output logic rd_on,
    output logic wr_on,
    output logic strobe_on,
    output logic clash
);
    always_comb begin
        if (style_sel) begin
            // enable + direction
            rd_on     = ctl_a & ctl_b;
            wr_on     = ctl_a & ~ctl_b;
            strobe_on = ctl_a;
            clash     = 1'b0;
        end else begin
            // split active-low strobes
            rd_on     = ~ctl_a & ctl_b;
            wr_on     = ~ctl_b & ctl_a;
            strobe_on = ~ctl_a | ~ctl_b;
            clash     = ~ctl_a & ~ctl_b;
        end
    end
endmodule

// File: rtl/hbd_bus_drive.sv
module hbd_bus_drive #(
    parameter int unsigned W = 8
) (
    input  logic         par_sel,
    input  logic         cs_n,
    input  logic         dc_sel,
    input  logic         rd_on,
    input  logic [W-1:0] status_in,
    input  logic [W-1:0] mem_in,
    output logic         oe,
    output logic [W-1:0] rd_byte
);
    always_comb begin
        oe      = par_sel & ~cs_n & rd_on;
        rd_byte = dc_sel ? mem_in : status_in;
    end
endmodule

// File: rtl/hbd_access_fsm.sv
module hbd_access_fsm
    import hbd_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel,
    input  logic         dc_sel,
    input  logic         rd_on,
    input  logic         wr_on,
    input  logic         strobe_on,
    input  logic         clash,
    input  logic [W-1:0] data,
    output logic         acc_valid,
    output logic [1:0]   acc_kind,
    output logic [W-1:0] acc_byte
);
    fsm_state_e state_q, state_d;
    acc_kind_e  kind_q;
    logic [W-1:0] byte_q;
    logic         open_ok;

    assign open_ok = sel & strobe_on & ~clash;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sel && clash)      state_d = ST_DRAIN;
                else if (sel && wr_on) state_d = ST_WR_ACT;
                else if (sel && rd_on) state_d = ST_RD_ACT;
            end
            ST_WR_ACT, ST_RD_ACT: begin
                if (!sel || clash)     state_d = ST_DRAIN;
                else if (!strobe_on)   state_d = ST_COMMIT;
            end
            ST_COMMIT: state_d = ST_IDLE;
            ST_DRAIN: begin
                if (!strobe_on)        state_d = ST_IDLE;
            end
            default:                   state_d = ST_IDLE;
        endcase
    end

    // kind and byte capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= K_CMD_WR;
            byte_q <= '0;
        end else begin
            if (state_q == ST_IDLE && sel && !clash && (wr_on || rd_on))
                kind_q <= acc_kind_e'({dc_sel, rd_on});
            if ((state_q == ST_WR_ACT || state_q == ST_RD_ACT) && open_ok)
                byte_q <= data;
        end
    end

    // outputs
    always_comb begin
        acc_valid = (state_q == ST_COMMIT);
        acc_kind  = kind_q;
        acc_byte  = byte_q;
    end

    p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> !acc_valid);

    p_commit_from_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT) |-> ($past(state_q) == ST_WR_ACT || $past(state_q) == ST_RD_ACT));

    p_abort_no_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WR_ACT || state_q == ST_RD_ACT) && !sel) |=> !acc_valid);

    p_read_kind_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_ACT) |-> kind_q[0]);

    p_write_kind_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WR_ACT) |-> !kind_q[0]);

    p_clash_no_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && clash) |=> (state_q != ST_WR_ACT && state_q != ST_RD_ACT));
endmodule

// File: rtl/host_bus_decoder.sv
module host_bus_decoder
    import hbd_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             par_sel,
    input  logic             style_sel,
    input  logic             cs_n,
    input  logic             dc_sel,
    input  logic             ctl_a,
    input  logic             ctl_b,
    inout  wire  [BUS_W-1:0] bus_io,
    output logic             bus_oe,
    input  logic [BUS_W-1:0] status_in,
    input  logic [BUS_W-1:0] mem_in,
    output logic             acc_valid,
    output logic [1:0]       acc_kind,
    output logic [BUS_W-1:0] acc_byte
);
    localparam pin_bundle_t PIN_RST = '{par_sel: 1'b0, style_sel: 1'b0, cs_n: 1'b1,
                                        dc_sel: 1'b0, ctl_a: 1'b1, ctl_b: 1'b1, data: '0};

    // asynchronous read path from raw pins
    logic             raw_rd, raw_wr, raw_strobe, raw_clash;
    logic [BUS_W-1:0] rd_byte;

    hbd_ctl_decode u_raw_dec (
        .style_sel (style_sel),
        .ctl_a     (ctl_a),
        .ctl_b     (ctl_b),
        .rd_on     (raw_rd),
        .wr_on     (raw_wr),
        .strobe_on (raw_strobe),
        .clash     (raw_clash)
    );

    hbd_bus_drive #(.W(BUS_W)) u_drive (
        .par_sel   (par_sel),
        .cs_n      (cs_n),
        .dc_sel    (dc_sel),
        .rd_on     (raw_rd),
        .status_in (status_in),
        .mem_in    (mem_in),
        .oe        (bus_oe),
        .rd_byte   (rd_byte)
    );

    assign bus_io = bus_oe ? rd_byte : 'z;

    // synchronised path
    pin_bundle_t pins_raw, pins_s;
    logic        s_rd, s_wr, s_strobe, s_clash;

    always_comb begin
        pins_raw.par_sel   = par_sel;
        pins_raw.style_sel = style_sel;
        pins_raw.cs_n      = cs_n;
        pins_raw.dc_sel    = dc_sel;
        pins_raw.ctl_a     = ctl_a;
        pins_raw.ctl_b     = ctl_b;
        pins_raw.data      = bus_io;
    end

    hbd_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_raw),
        .q     (pins_s)
    );

    hbd_ctl_decode u_sync_dec (
        .style_sel (pins_s.style_sel),
        .ctl_a     (pins_s.ctl_a),
        .ctl_b     (pins_s.ctl_b),
        .rd_on     (s_rd),
        .wr_on     (s_wr),
        .strobe_on (s_strobe),
        .clash     (s_clash)
    );

    hbd_access_fsm #(.W(BUS_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (pins_s.par_sel & ~pins_s.cs_n),
        .dc_sel    (pins_s.dc_sel),
        .rd_on     (s_rd),
        .wr_on     (s_wr),
        .strobe_on (s_strobe),
        .clash     (s_clash),
        .data      (pins_s.data),
        .acc_valid (acc_valid),
        .acc_kind  (acc_kind),
        .acc_byte  (acc_byte)
    );

    p_no_drive_unselected_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || !par_sel) |-> !bus_oe);

    p_no_drive_clash_r8: assert property (@(posedge clk) disable iff (!rst_n)
        raw_clash |-> !bus_oe);

    p_no_drive_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_wr || !raw_strobe) |-> !bus_oe);
endmodule

// File: tb/tb_host_bus_decoder.sv
`timescale 1ns/1ps
module tb_host_bus_decoder;
    localparam int SYNC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       par_sel, style_sel, cs_n, dc_sel, ctl_a, ctl_b;
    logic [7:0] status_in, mem_in, host_d;
    logic       host_oe;
    wire  [7:0] bus_io;
    logic       bus_oe, acc_valid;
    logic [1:0] acc_kind;
    logic [7:0] acc_byte;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    assign bus_io = host_oe ? host_d : 'z;

    always #2 clk = ~clk;

    host_bus_decoder #(.SYNC_STAGES(SYNC)) dut (
        .clk(clk), .rst_n(rst_n), .par_sel(par_sel), .style_sel(style_sel),
        .cs_n(cs_n), .dc_sel(dc_sel), .ctl_a(ctl_a), .ctl_b(ctl_b),
        .bus_io(bus_io), .bus_oe(bus_oe), .status_in(status_in), .mem_in(mem_in),
        .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_byte(acc_byte)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic go_idle(input bit style);
        par_sel = 1'b1; style_sel = style; cs_n = 1'b1; dc_sel = 1'b0;
        ctl_a = style ? 1'b0 : 1'b1; ctl_b = 1'b1; host_oe = 1'b0;
        repeat (SYNC + 3) @(negedge clk);
    endtask

    task automatic strobe_on(input bit style, input bit rd);
        if (style) begin ctl_a = 1'b1; ctl_b = rd; end
        else if (rd) ctl_a = 1'b0;
        else         ctl_b = 1'b0;
    endtask

    task automatic strobe_off(input bit style);
        ctl_a = style ? 1'b0 : 1'b1; ctl_b = 1'b1;
    endtask

    task automatic watch_none(input string req, input int n);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (acc_valid) seen++;
        end
        chk(req, "no acc_valid", seen, 0);
    endtask

    // R1 R2 R3 R4 R5 R10: one full access with edge-exact timing
    task automatic run_access(input bit style, input bit a0, input bit rd,
                              input logic [7:0] wdata, input logic [7:0] st, input logic [7:0] mm);
        logic [7:0] exp_byte;
        exp_byte = rd ? (a0 ? mm : st) : wdata;
        status_in = st; mem_in = mm;
        @(negedge clk);
        cs_n = 1'b0; dc_sel = a0;
        if (!rd) begin host_d = wdata; host_oe = 1'b1; end
        @(negedge clk);
        strobe_on(style, rd);
        repeat (4) @(negedge clk);
        chk("R5", "bus_oe during strobe", int'(bus_oe), int'(rd));
        if (rd) chk("R5", "bus_io read byte", int'(bus_io), int'(exp_byte));
        chk("R10", "no pulse during strobe", int'(acc_valid), 0);
        strobe_off(style);
        @(negedge clk);
        chk("R10", "edge 1 after trailing", int'(acc_valid), 0);
        cs_n = 1'b1; host_oe = 1'b0;
        @(negedge clk);
        chk("R10", "edge 2 after trailing", int'(acc_valid), 0);
        @(negedge clk);
        chk(style ? "R1" : "R2", "pulse at edge 3", int'(acc_valid), 1);
        chk("R3", "acc_kind", int'(acc_kind), int'({a0, rd}));
        chk("R4", "acc_byte", int'(acc_byte), int'(exp_byte));
        @(negedge clk);
        chk("R10", "pulse width one", int'(acc_valid), 0);
    endtask

    // R6 R7: strobe while deselected
    task automatic run_blocked(input bit style, input bit rd, input bit via_cs, input string req);
        status_in = 8'h3C; mem_in = 8'hC3;
        @(negedge clk);
        if (via_cs) cs_n = 1'b1; else begin cs_n = 1'b0; par_sel = 1'b0; end
        dc_sel = 1'b1;
        strobe_on(style, rd);
        repeat (4) @(negedge clk);
        chk(req, "bus_oe while deselected", int'(bus_oe), 0);
        strobe_off(style);
        watch_none(req, 2 * SYNC + 4);
        cs_n = 1'b1; par_sel = 1'b1;
    endtask

    initial begin
        go_idle(1'b0);
        status_in = 8'h00; mem_in = 8'h00; host_d = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11
        chk("R11", "acc_valid after reset", int'(acc_valid), 0);
        chk("R11", "acc_kind after reset", int'(acc_kind), 0);
        chk("R11", "acc_byte after reset", int'(acc_byte), 0);
        chk("R11", "bus_oe after reset", int'(bus_oe), 0);

        // main sweep
        for (int s = 0; s < 2; s++) begin
            go_idle(s[0]);
            for (int k = 0; k < 4; k++) begin
                for (int p = 0; p < 3; p++) begin
                    logic [7:0] wd, st, mm;
                    wd = 8'(p * 91 + k * 17 + s * 5 + 1);
                    st = 8'(p * 29 + 64 + k);
                    mm = 8'(255 - p * 43 - k * 3);
                    run_access(s[0], k[1], k[0], wd, st, mm);
                end
            end
        end

        // R6 and R7 in both styles
        for (int s = 0; s < 2; s++) begin
            go_idle(s[0]);
            run_blocked(s[0], 1'b1, 1'b1, "R6");
            run_blocked(s[0], 1'b0, 1'b1, "R6");
            run_blocked(s[0], 1'b1, 1'b0, "R7");
            run_blocked(s[0], 1'b0, 1'b0, "R7");
            run_access(s[0], 1'b1, 1'b0, 8'h5A, 8'h11, 8'h22);
        end

        // R8: clash, released together
        go_idle(1'b0);
        status_in = 8'h77; mem_in = 8'h88;
        @(negedge clk);
        cs_n = 1'b0; dc_sel = 1'b1; ctl_a = 1'b0; ctl_b = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8", "bus_oe on clash", int'(bus_oe), 0);
        ctl_a = 1'b1; ctl_b = 1'b1;
        watch_none("R8", 2 * SYNC + 4);
        cs_n = 1'b1;
        // R8: clash, write strobe released first, read strobe left low
        @(negedge clk);
        cs_n = 1'b0; ctl_a = 1'b0; ctl_b = 1'b0;
        repeat (4) @(negedge clk);
        ctl_b = 1'b1;
        repeat (4) @(negedge clk);
        ctl_a = 1'b1;
        watch_none("R8", 2 * SYNC + 4);
        cs_n = 1'b1;
        run_access(1'b0, 1'b0, 1'b1, 8'h00, 8'hA5, 8'h5A);

        // R9: chip select drops mid write, then strobe ends
        go_idle(1'b0);
        @(negedge clk);
        cs_n = 1'b0; dc_sel = 1'b1; host_d = 8'hE1; host_oe = 1'b1;
        @(negedge clk);
        ctl_b = 1'b0;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        ctl_b = 1'b1; host_oe = 1'b0;
        watch_none("R9", 2 * SYNC + 4);
        // R9: parallel select drops mid read in enable style
        go_idle(1'b1);
        @(negedge clk);
        cs_n = 1'b0; dc_sel = 1'b0;
        @(negedge clk);
        ctl_a = 1'b1; ctl_b = 1'b1;
        repeat (4) @(negedge clk);
        par_sel = 1'b0;
        repeat (3) @(negedge clk);
        ctl_a = 1'b0;
        watch_none("R9", 2 * SYNC + 4);
        cs_n = 1'b1; par_sel = 1'b1;
        run_access(1'b1, 1'b0, 1'b0, 8'h3D, 8'h00, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule